// File: doc/BRIEF.md
# Two-Level Bootstrap Election Hub

At power-up, every populated socket of a multi-socket system must agree on exactly one logical core that runs the firmware bootstrap. The other cores stay parked. This block performs the election in two stages.

In the first stage, each socket hub collects the election requests of its own cores during a short window and keeps the one with the highest priority. In the second stage, each hub that holds a local winner competes for a single system-wide master lock. The hub that obtains the lock places its winner's identifier on a shared broadcast bus for one cycle. Every core decodes that broadcast itself and raises its own boot flag only when the identifier is its own.

Sockets that are not populated, and cores that are fused off, send no requests. The election therefore completes correctly with any subset of them taking part.

Top module: `boot_elect_fabric`

## Requirements
- R1: Out of reset, `bcast_valid` is low, every bit of `lock_req` is low and every bit of `core_is_boot` is low.
- R2: A hub's collection window opens on the first clock edge at which one of its cores requests. It then spans exactly WINDOW consecutive edges. A request seen on any later edge has no effect on the election.
- R3: Within its window, a hub keeps the request with the numerically largest priority. Priority is the PRIO_W-bit field at bits [g*PRIO_W +: PRIO_W] of `core_prio` for global core g. Between equal priorities, the lower core index within the socket wins.
- R4: A hub raises its `lock_req` bit in the cycle after its window closes. The bit stays high until the hub is granted or a broadcast is seen. A hub whose cores never request never raises `lock_req`.
- R5: The lock is granted to at most one hub per reset. When several hubs request it in the same cycle, the lowest socket number wins.
- R6: The granted hub drives `bcast_valid` high for exactly one cycle, starting the cycle after its grant. During that cycle `bcast_id` carries socket*CORES + core index of its winner. Otherwise `bcast_id` is zero.
- R7: Exactly one broadcast occurs per reset. A hub still collecting or waiting when a broadcast is visible drops its `lock_req` on the next edge and never broadcasts. Requests after the broadcast are ignored.
- R8: On the edge after a broadcast, `core_is_boot[g]` becomes 1 for the core whose global index g equals `bcast_id` and 0 for all others. The flags then hold until reset.
- R9: The election completes with any populated subset of sockets, including a single socket or non-adjacent sockets. With no requests at all, no broadcast occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | SOCKETS*CORES | Election request, one bit per global core (socket*CORES + core) |
| core_prio | input | SOCKETS*CORES*PRIO_W | Arbitration priority of each core, PRIO_W bits per core |
| lock_req | output | SOCKETS | Per-hub request toward the system master lock |
| bcast_valid | output | 1 | One-cycle strobe of the winner broadcast |
| bcast_id | output | $clog2(SOCKETS*CORES) | Global identifier of the elected core |
| core_is_boot | output | SOCKETS*CORES | Per-core boot flag decoded from the broadcast |

## Verification
Two functions can land in the same cycle. One is the closing of a hub's collection window. The other is the broadcast from a hub that won the lock earlier. The bench provokes this by starting one socket a single cycle after another. The late hub then raises `lock_req` in exactly the cycle that `bcast_valid` is high, and it must withdraw on the following edge without a second broadcast. A second case has two hubs reach the lock in the same cycle. The lower socket must win, and the loser must stay silent. A behavioural model in the bench judges every cycle of both cases.

// File: rtl/boot_elect_pkg.sv
package boot_elect_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_COLLECT,
      PH_LOCK,
      PH_DONE
   } hub_phase_e;

endpackage

// File: rtl/local_pick.sv
module local_pick #(
   parameter int N  = 4,
   parameter int PW = 4,
   localparam int CW = $clog2(N)
) (
   input  logic [N-1:0]    valid,
   input  logic [N*PW-1:0] prio,
   output logic            any,
   output logic [PW-1:0]   best_prio,
   output logic [CW-1:0]   best_idx
);

   // strict compare keeps the lowest index among equal priorities
   always_comb begin
      any       = 1'b0;
      best_prio = '0;
      best_idx  = '0;
      for (int i = 0; i < N; i++) begin
         if (valid[i] && (!any || prio[i*PW +: PW] > best_prio)) begin
            any       = 1'b1;
            best_prio = prio[i*PW +: PW];
            best_idx  = CW'(i);
         end
      end
   end

endmodule

// File: rtl/elect_hub.sv
module elect_hub import boot_elect_pkg::*; #(
   parameter int N    = 4,
   parameter int PW   = 4,
   parameter int WIN  = 4,
   parameter int SOCK = 0,
   parameter int IDW  = 4,
   localparam int CW    = $clog2(N),
   localparam int CNT_W = $clog2(WIN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req_valid,
   input  logic [N*PW-1:0] req_prio,
   input  logic            bus_seen,
   input  logic            lock_gnt,
   output logic            lock_req,
   output logic            bcast_stb,
   output logic [IDW-1:0]  bcast_id
);

   hub_phase_e       phase;
   logic [CNT_W-1:0] cnt;
   logic             b_valid;
   logic [PW-1:0]    b_prio;
   logic [CW-1:0]    b_idx;
   logic             stb_r;

   logic             c_any;
   logic [PW-1:0]    c_prio;
   logic [CW-1:0]    c_idx;
   logic             take;
   logic             open_win;

   local_pick #(.N(N), .PW(PW)) u_pick (
      .valid    (req_valid),
      .prio     (req_prio),
      .any      (c_any),
      .best_prio(c_prio),
      .best_idx (c_idx)
   );

   assign take = c_any && (!b_valid || c_prio > b_prio ||
                           (c_prio == b_prio && c_idx < b_idx));
   assign open_win = (phase == PH_IDLE) || (phase == PH_COLLECT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         b_valid <= 1'b0;
         b_prio  <= '0;
         b_idx   <= '0;
         stb_r   <= 1'b0;
      end else begin
         stb_r <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (bus_seen) phase <= PH_DONE;
               else if (c_any) begin
                  phase <= PH_COLLECT;
                  cnt   <= CNT_W'(1);
               end
            end
            PH_COLLECT: begin
               if (bus_seen) phase <= PH_DONE;
               else begin
                  cnt <= cnt + 1'b1;
                  if (cnt == CNT_W'(WIN - 1)) phase <= PH_LOCK;
               end
            end
            PH_LOCK: begin
               if (bus_seen) phase <= PH_DONE;
               else if (lock_gnt) begin
                  stb_r <= 1'b1;
                  phase <= PH_DONE;
               end
            end
            default: ;
         endcase
         if (take && open_win && !bus_seen) begin
            b_valid <= 1'b1;
            b_prio  <= c_prio;
            b_idx   <= c_idx;
         end
      end
   end

   assign lock_req  = (phase == PH_LOCK);
   assign bcast_stb = stb_r;
   assign bcast_id  = stb_r ? (IDW'(SOCK * N) + IDW'(b_idx)) : '0;

   // R6: strobe lasts one cycle
   assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_stb |=> !bcast_stb);
   // R4: the lock is only requested with a local winner held
   assert_lock_has_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_req |-> b_valid);
   // R7: a waiting hub withdraws once a broadcast is visible
   assert_withdraw_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_req && bus_seen) |=> !lock_req && !bcast_stb);

endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter #(
   parameter int HUBS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [HUBS-1:0] req,
   output logic [HUBS-1:0] gnt
);

   logic held;

   // descending scan: the lowest requesting socket is assigned last
   always_comb begin
      gnt = '0;
      if (!held) begin
         for (int i = HUBS - 1; i >= 0; i--) begin
            if (req[i]) gnt = HUBS'(1) << i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held <= 1'b0;
      else if (|gnt) held <= 1'b1;
   end

   // R5: at most one hub granted
   assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   // R5: a grant never repeats after the lock is taken
   assert_no_regrant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt) |=> gnt == '0);

endmodule

// File: rtl/core_flag_decode.sv
module core_flag_decode #(
   parameter int TOTAL = 16,
   parameter int ID_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bcast_valid,
   input  logic [ID_W-1:0]  bcast_id,
   output logic [TOTAL-1:0] is_boot
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) is_boot <= '0;
      else if (bcast_valid) begin
         for (int i = 0; i < TOTAL; i++) begin
            is_boot[i] <= (bcast_id == ID_W'(i));
         end
      end
   end

   // R8: at most one boot flag
   assert_flags_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(is_boot));
   // R8: flag follows the broadcast identifier
   assert_flag_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_valid |=> is_boot == (TOTAL'(1) << $past(bcast_id)));

endmodule

// File: rtl/boot_elect_fabric.sv
module boot_elect_fabric import boot_elect_pkg::*; #(
   parameter int SOCKETS = 4,
   parameter int CORES   = 4,
   parameter int PRIO_W  = 4,
   parameter int WINDOW  = 4,
   localparam int TOTAL = SOCKETS * CORES,
   localparam int ID_W  = $clog2(TOTAL)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [TOTAL-1:0]           core_req,
   input  logic [TOTAL*PRIO_W-1:0]    core_prio,
   output logic [SOCKETS-1:0]         lock_req,
   output logic                       bcast_valid,
   output logic [ID_W-1:0]            bcast_id,
   output logic [TOTAL-1:0]           core_is_boot
);

   if (SOCKETS < 2) begin : g_bad_sockets
      $error("SOCKETS must be at least 2");
   end
   if (CORES < 2) begin : g_bad_cores
      $error("CORES must be at least 2");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("PRIO_W must be at least 1");
   end
   if (WINDOW < 2) begin : g_bad_window
      $error("WINDOW must be at least 2");
   end

   logic [SOCKETS-1:0] stb;
   logic [SOCKETS-1:0] gnt;
   logic [ID_W-1:0]    hub_id [SOCKETS];
   logic [ID_W-1:0]    bus_id;

   for (genvar s = 0; s < SOCKETS; s++) begin : g_hub
      elect_hub #(
         .N   (CORES),
         .PW  (PRIO_W),
         .WIN (WINDOW),
         .SOCK(s),
         .IDW (ID_W)
      ) u_hub (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_valid(core_req[s*CORES +: CORES]),
         .req_prio (core_prio[s*CORES*PRIO_W +: CORES*PRIO_W]),
         .bus_seen (bcast_valid),
         .lock_gnt (gnt[s]),
         .lock_req (lock_req[s]),
         .bcast_stb(stb[s]),
         .bcast_id (hub_id[s])
      );
   end

   lock_arbiter #(.HUBS(SOCKETS)) u_lock (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (lock_req),
      .gnt  (gnt)
   );

   always_comb begin
      bus_id = '0;
      for (int s = 0; s < SOCKETS; s++) bus_id |= hub_id[s];
   end

   assign bcast_valid = |stb;
   assign bcast_id    = bus_id;

   core_flag_decode #(.TOTAL(TOTAL), .ID_W(ID_W)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .bcast_valid(bcast_valid),
      .bcast_id   (bcast_id),
      .is_boot    (core_is_boot)
   );

   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           seen_q <= 1'b0;
      else if (bcast_valid) seen_q <= 1'b1;
   end

   // R7: hub strobes never overlap
   assert_bus_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb));
   // R7: no second broadcast after the first
   assert_single_broadcast_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> !bcast_valid);

endmodule

// File: tb/tb_boot_elect_fabric.sv
module tb_boot_elect_fabric;

   localparam int S  = 4;
   localparam int N  = 4;
   localparam int PW = 4;
   localparam int W  = 4;
   localparam int T  = S * N;
   localparam int IW = $clog2(T);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [T-1:0]    core_req = '0;
   logic [T*PW-1:0] core_prio = '0;
   logic [S-1:0]    lock_req;
   logic            bcast_valid;
   logic [IW-1:0]   bcast_id;
   logic [T-1:0]    core_is_boot;

   int n_cmp = 0;
   int n_bad = 0;
   int nb    = 0;

   always #2.5 clk = ~clk;

   boot_elect_fabric #(.SOCKETS(S), .CORES(N), .PRIO_W(PW), .WINDOW(W)) dut (
      .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_prio(core_prio),
      .lock_req(lock_req), .bcast_valid(bcast_valid), .bcast_id(bcast_id),
      .core_is_boot(core_is_boot)
   );

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // behavioural reference: per socket a stage and the start of its window
   int        stage [S];   // 0 waiting, 1 collecting, 2 lock, 3 finished
   int        start [S];
   bit        have  [S];
   int        bprio [S];
   int        bcore [S];
   int        cyc;
   bit        taken;
   bit        m_bv;
   int        m_id;
   logic [T-1:0] m_flag;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < S; s++) begin
            stage[s] = 0; start[s] = 0; have[s] = 0; bprio[s] = 0; bcore[s] = 0;
         end
         cyc = 0; taken = 0; m_bv = 0; m_id = 0; m_flag = '0;
      end else begin
         automatic bit seen = m_bv;
         automatic int winner = -1;
         automatic int fired = -1;
         if (m_bv) begin
            for (int g = 0; g < T; g++) m_flag[g] = (g == m_id);
         end
         if (!taken) begin
            for (int s = S - 1; s >= 0; s--) if (stage[s] == 2) winner = s;
         end
         for (int s = 0; s < S; s++) begin
            if (stage[s] < 3 && seen) stage[s] = 3;
            else if (stage[s] == 2) begin
               if (winner == s) begin fired = s; stage[s] = 3; end
            end else if (stage[s] < 2) begin
               for (int c = 0; c < N; c++) begin
                  automatic int g = s * N + c;
                  automatic int p = int'(core_prio[g*PW +: PW]);
                  if (core_req[g] && (!have[s] || p > bprio[s] ||
                                      (p == bprio[s] && c < bcore[s]))) begin
                     have[s] = 1; bprio[s] = p; bcore[s] = c;
                  end
               end
               if (stage[s] == 0 && have[s]) begin stage[s] = 1; start[s] = cyc; end
               if (stage[s] == 1 && cyc - start[s] == W - 1) stage[s] = 2;
            end
         end
         if (winner >= 0) taken = 1;
         m_bv = (fired >= 0);
         m_id = (fired >= 0) ? fired * N + bcore[fired] : 0;
         cyc++;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R6 bcast_valid", int'(bcast_valid), int'(m_bv));
         chk("R6 bcast_id", int'(bcast_id), m_bv ? m_id : 0);
         chk("R8 core_is_boot", int'(core_is_boot), int'(m_flag));
         for (int s = 0; s < S; s++)
            chk("R4 lock_req", int'(lock_req[s]), int'(stage[s] == 2));
         if (bcast_valid) nb++;
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      core_req = '0;
      core_prio = '0;
      repeat (3) @(negedge clk);
      nb = 0;
      rst_n = 1'b1;
   endtask

   task automatic put(int g, int p);
      core_req[g] = 1'b1;
      core_prio[g*PW +: PW] = PW'(p);
   endtask

   task automatic idle(int n);
      core_req = '0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      do_reset();
      @(negedge clk);
      // R1: quiet after reset
      chk("R1 bcast_valid", int'(bcast_valid), 0);
      chk("R1 lock_req", int'(lock_req), 0);
      chk("R1 core_is_boot", int'(core_is_boot), 0);

      // single requester in socket 2, core 1
      put(9, 5);
      @(negedge clk);
      core_req = '0;
      repeat (3) @(negedge clk);
      chk("R4 lock raised after window", int'(lock_req), 4);
      @(negedge clk);
      chk("R6 strobe", int'(bcast_valid), 1);
      chk("R6 id", int'(bcast_id), 9);
      @(negedge clk);
      chk("R6 strobe one cycle", int'(bcast_valid), 0);
      chk("R8 own flag", int'(core_is_boot), 1 << 9);
      idle(4);
      chk("R7 one broadcast", nb, 1);

      // priority, tie and late request in socket 0
      do_reset();
      put(3, 2); @(negedge clk);
      core_req = '0; put(1, 7); @(negedge clk);
      core_req = '0; put(2, 7); @(negedge clk);
      idle(1);
      put(0, 15); @(negedge clk);
      idle(4);
      chk("R3 tie to lower core", int'(core_is_boot), 1 << 1);
      chk("R2 late request ignored", nb, 1);

      // two hubs reach the lock together
      do_reset();
      put(4, 1); put(14, 15); @(negedge clk);
      idle(8);
      chk("R5 lowest socket wins", int'(core_is_boot), 1 << 4);
      chk("R7 loser silent", nb, 1);

      // window close collides with another hub's broadcast
      do_reset();
      put(14, 3); @(negedge clk);
      core_req = '0; put(0, 15); @(negedge clk);
      core_req = '0;
      repeat (3) @(negedge clk);
      chk("R7 collision strobe", int'(bcast_valid), 1);
      chk("R7 collision lock_req", int'(lock_req), 1);
      @(negedge clk);
      chk("R7 withdrawn", int'(lock_req), 0);
      put(5, 9); @(negedge clk);
      idle(8);
      chk("R7 single broadcast", nb, 1);
      chk("R9 later socket elected", int'(core_is_boot), 1 << 14);

      // no requests at all
      do_reset();
      idle(30);
      chk("R9 no broadcast", nb, 0);
      chk("R4 no lock", int'(lock_req), 0);

      // every core requests at once
      do_reset();
      for (int g = 0; g < T; g++) put(g, (g % N) + 1);
      @(negedge clk);
      idle(8);
      chk("R9 full population", int'(core_is_boot), 1 << 3);
      chk("R9 one broadcast", nb, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5ns * 20000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule